// File: doc/BRIEF.md
# Radio Activity Indicator Driver

This block drives a small bank of indicator lines, typically front-panel lamps, from the current activity of one radio channel. Two activity flags from the datapath, one for receive and one for transmit, are sampled into a registered four-way activity state. The state picks one of four host-written pattern registers, and that pattern goes to the indicator lines.

A host writes the patterns and a few control registers through a plain address/data write port. An antenna-select register records which port carries receive traffic: the shared transmit/receive port or the dedicated receive port. When only receive is active and the shared port is selected, the block swaps the "shared port receiving" and "dedicated port receiving" bits of the receive-only pattern. The host therefore writes one receive pattern, and the lamp that lights follows the antenna choice. A mask and value pair lets the host force chosen lines to fixed levels in every state.

The indicator bit meanings used throughout are: bit 0 means the shared port is receiving, bit 1 means the shared port is transmitting, and bit 2 means the dedicated receive port is receiving. With the usual patterns loaded, the lines read 000 when idle, 100 or 001 for receive-only depending on the antenna, 010 for transmit-only and 110 for full duplex.

Top module: `act_lamp_drv`

## Requirements
- R1: After reset every writable register is zero, the activity state is idle and all indicator lines are low.
- R2: The activity state is {tx_active, rx_active}, with 00 idle, 01 receive-only, 10 transmit-only and 11 full-duplex. It is registered on the rising clock edge, so the lines reflect the flags sampled at the previous edge and do not change before that edge.
- R3: Pattern registers are at addresses 0 (idle), 1 (receive-only), 2 (transmit-only) and 3 (full-duplex). In idle, transmit-only and full-duplex, with no override, the lines equal the pattern for that state.
- R4: In receive-only with antenna-select bit 0 clear (dedicated receive port), the lines equal the receive-only pattern unchanged.
- R5: In receive-only with antenna-select bit 0 set (shared port), bits 0 and 2 of the receive-only pattern are exchanged and all other bits pass unchanged.
- R6: The antenna-select register (address 4, bit 0) has no effect on the lines in idle, transmit-only or full-duplex.
- R7: A register write takes effect on the clock edge where wr_en is high. With wr_en low, address and data are ignored.
- R8: Override mask (address 5) and override value (address 6): each line whose mask bit is 1 shows the value bit, in every state. Each other line shows the state pattern.
- R9: Writes to address 7 change no register and no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | LINES | Write data |
| rx_active | input | 1 | Receive activity flag |
| tx_active | input | 1 | Transmit activity flag |
| lamp_out | output | LINES | Indicator lines |

## Verification
The assertions assume that the activity flags and the write port change only between rising edges. They also assume the flags are low and wr_en is idle while reset is held, so the first tracked state after reset is defined. The stimulus drives every input on the falling edge from tasks and holds both flags and wr_en low through reset. Writes with wr_en low and writes to the unused address are deliberate. They exercise the hold and ignore properties without breaking these assumptions.

// File: rtl/act_lamp_pkg.sv
package act_lamp_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'b00,
      ACT_RX     = 2'b01,
      ACT_TX     = 2'b10,
      ACT_DUPLEX = 2'b11
   } act_state_e;

   localparam int unsigned REG_ADDR_W = 3;
   localparam int unsigned NUM_STATES = 4;

   // pattern registers sit at addresses 0..3, indexed by state code
   localparam logic [REG_ADDR_W-1:0] ADR_ANT  = 3'd4;
   localparam logic [REG_ADDR_W-1:0] ADR_MASK = 3'd5;
   localparam logic [REG_ADDR_W-1:0] ADR_MVAL = 3'd6;

endpackage

// File: rtl/act_lamp_regs.sv
module act_lamp_regs
   import act_lamp_pkg::*;
#(
   parameter int unsigned LINES = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [REG_ADDR_W-1:0]                 wr_addr,
   input  logic [LINES-1:0]                      wr_data,
   output logic [NUM_STATES-1:0][LINES-1:0]      pat_q,
   output logic                                  ant_shared_q,
   output logic [LINES-1:0]                      mask_q,
   output logic [LINES-1:0]                      mval_q
);

   genvar g;
   generate
      for (g = 0; g < NUM_STATES; g++) begin : g_pat
         always_ff @(posedge clk) begin
            if (!rst_n)
               pat_q[g] <= '0;
            else if (wr_en && (wr_addr == REG_ADDR_W'(g)))
               pat_q[g] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ant_shared_q <= 1'b0;
         mask_q       <= '0;
         mval_q       <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_ANT)  ant_shared_q <= wr_data[0];
         if (wr_addr == ADR_MASK) mask_q       <= wr_data;
         if (wr_addr == ADR_MVAL) mval_q       <= wr_data;
      end
   end

   // R7: no strobe, no register change
   a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pat_q) && $stable(ant_shared_q) && $stable(mask_q) && $stable(mval_q)));

   // R9: the spare address touches nothing
   a_r9_spare_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd7) |=> ($stable(pat_q) && $stable(ant_shared_q) && $stable(mask_q) && $stable(mval_q)));

   // R7: a strobed write lands on the next edge
   a_r7_mask_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_MASK) |=> (mask_q == $past(wr_data)));

endmodule

// File: rtl/act_lamp_state.sv
module act_lamp_state
   import act_lamp_pkg::*;
#(
   parameter int unsigned STAGES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_active,
   input  logic       tx_active,
   output act_state_e state_q
);

   generate
      if (STAGES == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= ACT_IDLE;
            else        state_q <= act_state_e'({tx_active, rx_active});
         end

         // R2: state tracks the flags sampled one edge earlier
         a_r2_state_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (state_q == act_state_e'($past({tx_active, rx_active}))));
      end else if (STAGES == 2) begin : g_sync
         logic [1:0] flags_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_q <= 2'b00;
               state_q <= ACT_IDLE;
            end else begin
               flags_q <= {tx_active, rx_active};
               state_q <= act_state_e'(flags_q);
            end
         end
      end else begin : g_bad_stages
         $error("act_lamp_state: STAGES must be 1 or 2");
      end
   endgenerate

endmodule

// File: rtl/act_lamp_sel.sv
module act_lamp_sel
   import act_lamp_pkg::*;
#(
   parameter int unsigned LINES      = 4,
   parameter int unsigned SH_RX_BIT  = 0,
   parameter int unsigned DED_RX_BIT = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  act_state_e                        state_q,
   input  logic [NUM_STATES-1:0][LINES-1:0]  pat_q,
   input  logic                              ant_shared_q,
   input  logic [LINES-1:0]                  mask_q,
   input  logic [LINES-1:0]                  mval_q,
   output logic [LINES-1:0]                  lamp_out
);

   logic [LINES-1:0] chosen;
   logic [LINES-1:0] steered;
   logic             swap_rx;

   always_comb begin
      chosen  = pat_q[state_q];
      swap_rx = (state_q == ACT_RX) && ant_shared_q;
   end

   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_bit
         if (i == SH_RX_BIT) begin : g_sh
            assign steered[i] = swap_rx ? chosen[DED_RX_BIT] : chosen[i];
         end else if (i == DED_RX_BIT) begin : g_ded
            assign steered[i] = swap_rx ? chosen[SH_RX_BIT] : chosen[i];
         end else begin : g_pass
            assign steered[i] = chosen[i];
         end
         assign lamp_out[i] = mask_q[i] ? mval_q[i] : steered[i];
      end
   endgenerate

   // R8: forced lines show the override value
   a_r8_forced_lines: assert property (@(posedge clk) disable iff (!rst_n)
      ((lamp_out & mask_q) == (mval_q & mask_q)));

   // R3 / R6: outside receive-only the pattern passes straight through
   a_r6_no_steer_outside_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ACT_RX && mask_q == '0) |-> (lamp_out == pat_q[state_q]));

   // R5: shared antenna moves the dedicated-receive bit onto the shared-receive line
   a_r5_shared_rx_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ACT_RX && ant_shared_q && mask_q == '0)
         |-> (lamp_out[SH_RX_BIT] == pat_q[ACT_RX][DED_RX_BIT]
              && lamp_out[DED_RX_BIT] == pat_q[ACT_RX][SH_RX_BIT]));

   // R4: dedicated antenna leaves the receive pattern alone
   a_r4_dedicated_rx_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ACT_RX && !ant_shared_q && mask_q == '0) |-> (lamp_out == pat_q[ACT_RX]));

endmodule

// File: rtl/act_lamp_drv.sv
module act_lamp_drv
   import act_lamp_pkg::*;
#(
   parameter int unsigned LINES      = 4,
   parameter int unsigned SH_RX_BIT  = 0,
   parameter int unsigned DED_RX_BIT = 2,
   parameter int unsigned STAGES     = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_addr,
   input  logic [LINES-1:0]      wr_data,
   input  logic                  rx_active,
   input  logic                  tx_active,
   output logic [LINES-1:0]      lamp_out
);

   generate
      if (LINES < 3 || LINES > 32) begin : g_bad_lines
         $error("act_lamp_drv: LINES must be 3..32");
      end
      if (SH_RX_BIT >= LINES || DED_RX_BIT >= LINES || SH_RX_BIT == DED_RX_BIT) begin : g_bad_bits
         $error("act_lamp_drv: receive indicator bits must be distinct and inside LINES");
      end
   endgenerate

   act_state_e                       state_q;
   logic [NUM_STATES-1:0][LINES-1:0] pat_q;
   logic                             ant_shared_q;
   logic [LINES-1:0]                 mask_q;
   logic [LINES-1:0]                 mval_q;

   act_lamp_regs #(.LINES(LINES)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .pat_q        (pat_q),
      .ant_shared_q (ant_shared_q),
      .mask_q       (mask_q),
      .mval_q       (mval_q)
   );

   act_lamp_state #(.STAGES(STAGES)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_active (rx_active),
      .tx_active (tx_active),
      .state_q   (state_q)
   );

   act_lamp_sel #(
      .LINES      (LINES),
      .SH_RX_BIT  (SH_RX_BIT),
      .DED_RX_BIT (DED_RX_BIT)
   ) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .state_q      (state_q),
      .pat_q        (pat_q),
      .ant_shared_q (ant_shared_q),
      .mask_q       (mask_q),
      .mval_q       (mval_q),
      .lamp_out     (lamp_out)
   );

   // R1: idle with idle pattern and mask both cleared drives nothing
   a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ACT_IDLE && pat_q[0] == '0 && mask_q == '0) |-> (lamp_out == '0));

endmodule

// File: tb/sim_act_lamp_drv.sv
`timescale 1ns/1ps
module sim_act_lamp_drv;

   localparam int unsigned LINES = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [LINES-1:0] wr_data = '0;
   logic             rx_active = 1'b0;
   logic             tx_active = 1'b0;
   logic [LINES-1:0] lamp_out;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          done     = 1'b0;

   // bench-side view of the register map, kept from the requirements
   logic [LINES-1:0] m_pat [4];
   logic             m_ant;
   logic [LINES-1:0] m_mask, m_mval;

   always #2.5 clk = ~clk;

   act_lamp_drv #(.LINES(LINES)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rx_active(rx_active), .tx_active(tx_active), .lamp_out(lamp_out)
   );

   function automatic logic [LINES-1:0] expect_lines(input logic tx, input logic rx);
      logic [LINES-1:0] p;
      logic [LINES-1:0] s;
      p = m_pat[{tx, rx}];
      s = p;
      if ({tx, rx} == 2'b01 && m_ant) begin
         s[0] = p[2];
         s[2] = p[0];
      end
      return (s & ~m_mask) | (m_mval & m_mask);
   endfunction

   task automatic check(input string req, input logic [LINES-1:0] got, input logic [LINES-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: lamp_out got %b expected %b", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [LINES-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         3'd0, 3'd1, 3'd2, 3'd3: m_pat[a[1:0]] = d;
         3'd4: m_ant  = d[0];
         3'd5: m_mask = d;
         3'd6: m_mval = d;
         default: ;
      endcase
   endtask

   task automatic set_act(input logic tx, input logic rx);
      @(negedge clk);
      tx_active = tx; rx_active = rx;
      @(negedge clk);
   endtask

   task automatic sweep_states(input string req);
      for (int s = 0; s < 4; s++) begin
         set_act(s[1], s[0]);
         check(req, lamp_out, expect_lines(s[1], s[0]));
      end
   endtask

   task automatic t_reset;
      // R1: dark after reset, even with activity since all patterns are zero
      check("R1", lamp_out, '0);
      set_act(1'b1, 1'b1);
      check("R1", lamp_out, '0);
      set_act(1'b0, 1'b0);
   endtask

   task automatic t_usual_patterns;
      reg_write(3'd0, 4'b0000);
      reg_write(3'd1, 4'b0100);
      reg_write(3'd2, 4'b0010);
      reg_write(3'd3, 4'b0110);
      // R3 and R4: dedicated antenna, each state shows its pattern
      set_act(1'b0, 1'b1); check("R4", lamp_out, 4'b0100);
      set_act(1'b1, 1'b0); check("R3", lamp_out, 4'b0010);
      set_act(1'b1, 1'b1); check("R3", lamp_out, 4'b0110);
      set_act(1'b0, 1'b0); check("R3", lamp_out, 4'b0000);
   endtask

   task automatic t_antenna;
      reg_write(3'd4, 4'b0001);
      set_act(1'b0, 1'b1); check("R5", lamp_out, 4'b0001);
      // R6: other states unaffected by antenna choice
      set_act(1'b1, 1'b0); check("R6", lamp_out, 4'b0010);
      set_act(1'b1, 1'b1); check("R6", lamp_out, 4'b0110);
      set_act(1'b0, 1'b0); check("R6", lamp_out, 4'b0000);
      // R5: upper bits pass, bits 0 and 2 exchange
      reg_write(3'd1, 4'b1001);
      set_act(1'b0, 1'b1); check("R5", lamp_out, 4'b1100);
      reg_write(3'd4, 4'b0000);
      check("R4", lamp_out, 4'b1001);
   endtask

   task automatic t_timing;
      // R2: output holds until the edge after the flags change
      set_act(1'b0, 1'b0);
      @(negedge clk);
      tx_active = 1'b1; rx_active = 1'b0;
      #1;
      check("R2", lamp_out, 4'b0000);
      @(negedge clk);
      check("R2", lamp_out, 4'b0010);
      // R7: address and data without strobe are ignored
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 3'd2; wr_data = 4'b1111;
      @(negedge clk);
      @(negedge clk);
      check("R7", lamp_out, 4'b0010);
      // R7: strobed write visible right after its edge
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 4'b1010;
      #1;
      check("R7", lamp_out, 4'b0010);
      @(negedge clk);
      wr_en = 1'b0;
      m_pat[2] = 4'b1010;
      check("R7", lamp_out, 4'b1010);
   endtask

   task automatic t_override;
      reg_write(3'd6, 4'b0001);
      reg_write(3'd5, 4'b0011);
      sweep_states("R8");
      reg_write(3'd4, 4'b0001);
      sweep_states("R8");
      reg_write(3'd5, 4'b0000);
      sweep_states("R8");
   endtask

   task automatic t_spare;
      // R9: spare address writes do nothing
      reg_write(3'd7, 4'b1111);
      sweep_states("R9");
      reg_write(3'd7, 4'b0000);
      sweep_states("R9");
   endtask

   initial begin
      for (int k = 0; k < 4; k++) m_pat[k] = '0;
      m_ant = 1'b0; m_mask = '0; m_mval = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_usual_patterns();
      t_antenna();
      t_timing();
      t_override();
      t_spare();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule